// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a bank of eight binary lock tokens shared by two agents, a left port and a right port. Each agent reaches a token with a select strobe and a 3-bit index. A write whose data bit 0 is 0 asks for the token, and a write whose bit 0 is 1 gives it back. A read returns that side's view of the token, active low: 0 means the side holds it and 1 means it does not. The view is spread across the whole 18-bit read bus. The block sees only accesses that are already decoded. Memory addressing and chip enables are handled elsewhere.

Each token keeps one request latch per side and an owner state. A side that asks while the other side holds the token is not refused. Its request stays in its latch, and ownership moves to it in the same cycle that the holder releases. When both sides ask for a free token in the same clock cycle, the left side wins and the right request stays pending. A read is captured in the cycle in which it starts. The value then stays fixed for as long as the read strobes stay active, even if the other side changes the token in the meantime.

Top module: `sema_bank`

## Requirements
- R1: While rst_n is low at a rising clock edge, every request latch is set to 1 (idle) and every token becomes free. After reset, a read of any token returns 18'h3FFFF on either side.
- R2: The 3-bit index selects one of eight tokens. An access to one index leaves every other token unchanged.
- R3: A write (sel=1, we=1) uses only wdata bit 0. Bits 17..1 have no effect.
- R4: When a side writes 0 to a free token, that side owns the token from the next clock edge. Its reads then return 18'h00000 and the other side's reads return 18'h3FFFF. Writes from the side that does not own the token cannot take it away or release it.
- R5: A 0 written by the side that does not own the token is kept as a pending request. When the owner writes 1, ownership passes to the waiting side in the same cycle.
- R6: When the owner writes 1 and no request is pending on the other side, the token becomes free, and both sides read 18'h3FFFF.
- R7: When both sides write 0 to the same free token in the same cycle, the left side gets the token and the right request stays pending.
- R8: A read is active when sel=1, oe=1 and we=0. rdata carries the side's flag copied onto all 18 bits while a read is active and has been active for at least one clock edge. Otherwise rdata is 18'h00000.
- R9: The read value is taken at the first clock edge of an active read. It does not change while the read stays active, whatever the other side writes or whatever the index does.
- R10: A side that does not own the token can withdraw its pending request by writing 1. A later release by the owner then leaves the token free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_sel | input | 1 | Left token access select |
| l_oe | input | 1 | Left read enable |
| l_we | input | 1 | Left write strobe |
| l_addr | input | 3 | Left token index |
| l_wdata | input | 18 | Left write data (bit 0 used) |
| l_rdata | output | 18 | Left read data |
| r_sel | input | 1 | Right token access select |
| r_oe | input | 1 | Right read enable |
| r_we | input | 1 | Right write strobe |
| r_addr | input | 3 | Right token index |
| r_wdata | input | 18 | Right write data (bit 0 used) |
| r_rdata | output | 18 | Right read data |

## Verification
Two functions can land on the same token in the same cycle. The first is a request from each side at once. The second is the owner's release coinciding with a read on the waiting side, where the handover must not reach the frozen read value. Directed sequences provoke both cases: a same-cycle request from both sides on a free token, and a release issued while the waiting side holds a read open. A random phase biased towards indices 0 and 1 produces many more such collisions. Each cycle's read data on both sides is judged against a bench reference model of latches, owners and captured read values.

// File: rtl/sema_pkg.sv
// Shared types for the semaphore bank.
// Assumes: two sides only; owner code 0 means the token is free.
package sema_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/sema_port_dec.sv
// Decodes one side's access strobes into a one-hot write vector and a read-active flag.
// Assumes: strobes are synchronous to clk and already qualified by upstream decoding.
module sema_port_dec #(
    parameter int N_SEM = 8,
    parameter int AW    = $clog2(N_SEM)
) (
    input  logic             sel,
    input  logic             oe,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    output logic [N_SEM-1:0] wr_hit,
    output logic             rd_act
);
    // One write enable per token, set only for the indexed token.
    always_comb begin
        for (int i = 0; i < N_SEM; i++) begin
            wr_hit[i] = sel && we && (addr == AW'(i));
        end
    end

    // A read needs select and output enable with no write strobe.
    assign rd_act = sel && oe && !we;
endmodule

// File: rtl/sema_cell.sv
// One token: one request latch per side plus a registered owner.
// Assumes: latches are active low (0 = request). A same-cycle tie on a free token goes left.
module sema_cell
    import sema_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       l_wr,
    input  logic       l_bit,
    input  logic       r_wr,
    input  logic       r_bit,
    output logic       l_flag,
    output logic       r_flag,
    output logic [1:0] own_o,
    output logic       req_l_o,
    output logic       req_r_o
);
    logic   req_l_q, req_r_q, req_l_d, req_r_d;
    owner_e own_q, own_d;

    // Next latch values and the owner they imply.
    always_comb begin
        req_l_d = l_wr ? l_bit : req_l_q;
        req_r_d = r_wr ? r_bit : req_r_q;
        case (own_q)
            OWN_LEFT:  own_d = !req_l_d ? OWN_LEFT  : (!req_r_d ? OWN_RIGHT : OWN_NONE);
            OWN_RIGHT: own_d = !req_r_d ? OWN_RIGHT : (!req_l_d ? OWN_LEFT  : OWN_NONE);
            default:   own_d = !req_l_d ? OWN_LEFT  : (!req_r_d ? OWN_RIGHT : OWN_NONE);
        endcase
    end

    // State registers; reset clears both requests and frees the token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_l_q <= 1'b1;
            req_r_q <= 1'b1;
            own_q   <= OWN_NONE;
        end else begin
            req_l_q <= req_l_d;
            req_r_q <= req_r_d;
            own_q   <= own_d;
        end
    end

    assign l_flag  = (own_q != OWN_LEFT);
    assign r_flag  = (own_q != OWN_RIGHT);
    assign own_o   = own_q;
    assign req_l_o = req_l_q;
    assign req_r_o = req_r_q;
endmodule

// File: rtl/sema_read_hold.sv
// Freezes one side's read value for the life of a read.
// Assumes: flag_in is the side's flag for the currently indexed token.
module sema_read_hold #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_act,
    input  logic          flag_in,
    output logic [DW-1:0] rdata
);
    logic          rd_q;
    logic [DW-1:0] hold_q;

    // Capture on the first edge of a read, then hold until the read ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            hold_q <= '0;
        end else begin
            rd_q <= rd_act;
            if (rd_act && !rd_q) begin
                hold_q <= {DW{flag_in}};
            end
        end
    end

    assign rdata = (rd_act && rd_q) ? hold_q : '0;
endmodule

// File: rtl/sema_bank.sv
// Top: bank of N_SEM tokens shared by a left and a right side.
// Assumes: accesses are pre-decoded; only wdata bit 0 is meaningful on writes.
module sema_bank #(
    parameter int N_SEM = 8,
    parameter int DW    = 18,
    parameter int AW    = $clog2(N_SEM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_sel,
    input  logic          l_oe,
    input  logic          l_we,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    input  logic          r_sel,
    input  logic          r_oe,
    input  logic          r_we,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata
);
    logic [N_SEM-1:0]   l_hit, r_hit, l_flag_vec, r_flag_vec;
    logic [N_SEM-1:0]   reql_vec, reqr_vec;
    logic [2*N_SEM-1:0] own_vec;
    logic               l_rd, r_rd;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^{l_wdata[DW-1:1], r_wdata[DW-1:1]};

    sema_port_dec #(.N_SEM(N_SEM), .AW(AW)) u_dec_l (
        .sel(l_sel), .oe(l_oe), .we(l_we), .addr(l_addr),
        .wr_hit(l_hit), .rd_act(l_rd)
    );
    sema_port_dec #(.N_SEM(N_SEM), .AW(AW)) u_dec_r (
        .sel(r_sel), .oe(r_oe), .we(r_we), .addr(r_addr),
        .wr_hit(r_hit), .rd_act(r_rd)
    );

    for (genvar i = 0; i < N_SEM; i++) begin : g_cell
        sema_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_wr(l_hit[i]), .l_bit(l_wdata[0]),
            .r_wr(r_hit[i]), .r_bit(r_wdata[0]),
            .l_flag(l_flag_vec[i]), .r_flag(r_flag_vec[i]),
            .own_o(own_vec[2*i +: 2]),
            .req_l_o(reql_vec[i]), .req_r_o(reqr_vec[i])
        );
    end

    sema_read_hold #(.DW(DW)) u_hold_l (
        .clk(clk), .rst_n(rst_n), .rd_act(l_rd),
        .flag_in(l_flag_vec[l_addr]), .rdata(l_rdata)
    );
    sema_read_hold #(.DW(DW)) u_hold_r (
        .clk(clk), .rst_n(rst_n), .rd_act(r_rd),
        .flag_in(r_flag_vec[r_addr]), .rdata(r_rdata)
    );
endmodule

// File: rtl/sema_bank_chk.sv
// Property checker for sema_bank, attached by bind below.
// Assumes: own_vec packs one 2-bit owner code per token (0 free, 1 left, 2 right).
module sema_bank_chk
    import sema_pkg::*;
#(
    parameter int N_SEM = 8,
    parameter int DW    = 18,
    parameter int AW    = $clog2(N_SEM)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sel, l_oe, l_we,
    input logic [AW-1:0]      l_addr,
    input logic [DW-1:0]      l_wdata,
    input logic [DW-1:0]      l_rdata,
    input logic               r_sel, r_oe, r_we,
    input logic [AW-1:0]      r_addr,
    input logic [DW-1:0]      r_wdata,
    input logic [DW-1:0]      r_rdata,
    input logic [2*N_SEM-1:0] own_vec,
    input logic [N_SEM-1:0]   reqr_vec
);
    logic [AW-1:0] la_q, ra_q;
    logic          lw, rw, lrd, rrd, same;

    // Remember last cycle's indices for next-cycle owner checks.
    always_ff @(posedge clk) begin
        la_q <= l_addr;
        ra_q <= r_addr;
    end

    function automatic logic [1:0] own_at(input logic [2*N_SEM-1:0] v, input logic [AW-1:0] a);
        return v[2*a +: 2];
    endfunction

    assign lw   = l_sel && l_we;
    assign rw   = r_sel && r_we;
    assign lrd  = l_sel && l_oe && !l_we;
    assign rrd  = r_sel && r_oe && !r_we;
    assign same = (l_addr == r_addr);

    a_r4_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
        (lw && !l_wdata[0] && own_at(own_vec, l_addr) == OWN_NONE) |=> own_at(own_vec, la_q) == OWN_LEFT);

    a_r4_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rw && own_at(own_vec, r_addr) == OWN_LEFT && !(lw && same)) |=> own_at(own_vec, ra_q) == OWN_LEFT);

    a_r5_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (lw && l_wdata[0] && own_at(own_vec, l_addr) == OWN_LEFT && !reqr_vec[l_addr] && !(rw && same))
        |=> own_at(own_vec, la_q) == OWN_RIGHT);

    a_r6_release_free: assert property (@(posedge clk) disable iff (!rst_n)
        (lw && l_wdata[0] && own_at(own_vec, l_addr) == OWN_LEFT && reqr_vec[l_addr] && !(rw && same))
        |=> own_at(own_vec, la_q) == OWN_NONE);

    a_r7_tie_left: assert property (@(posedge clk) disable iff (!rst_n)
        (lw && rw && same && !l_wdata[0] && !r_wdata[0] && own_at(own_vec, l_addr) == OWN_NONE)
        |=> own_at(own_vec, la_q) == OWN_LEFT);

    a_r8_replicate: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(l_rdata) == 0 || $countones(l_rdata) == DW) &&
        ($countones(r_rdata) == 0 || $countones(r_rdata) == DW));

    a_r9_freeze_l: assert property (@(posedge clk) disable iff (!rst_n)
        (lrd && $past(lrd) && $past(lrd, 2) && $past(rst_n) && $past(rst_n, 2)) |-> $stable(l_rdata));

    a_r9_freeze_r: assert property (@(posedge clk) disable iff (!rst_n)
        (rrd && $past(rrd) && $past(rrd, 2) && $past(rst_n) && $past(rst_n, 2)) |-> $stable(r_rdata));
endmodule

bind sema_bank sema_bank_chk #(.N_SEM(N_SEM), .DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_oe(l_oe), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_oe(r_oe), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .own_vec(own_vec), .reqr_vec(reqr_vec)
);

// File: tb/sim_sema_bank.sv
module sim_sema_bank;
    localparam int N  = 8;
    localparam int DW = 18;
    localparam logic [DW-1:0] ONES = '1;
    localparam logic [DW-1:0] ZERO = '0;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          l_sel, l_oe, l_we, r_sel, r_oe, r_we;
    logic [2:0]    l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    sema_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_oe(l_oe), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_oe(r_oe), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model: request latches (1 idle), owner 0 free / 1 left / 2 right.
    logic          m_rl [N];
    logic          m_rr [N];
    int            m_own [N];
    logic          pl, pr;
    logic [DW-1:0] hl, hr;

    function automatic logic mflag(input int side, input int i);
        return (side == 0) ? (m_own[i] != 1) : (m_own[i] != 2);
    endfunction

    function automatic int next_own(input int cur, input logic nl, input logic nr);
        if (cur == 2) return !nr ? 2 : (!nl ? 1 : 0);
        if (cur == 1) return !nl ? 1 : (!nr ? 2 : 0);
        return !nl ? 1 : (!nr ? 2 : 0);
    endfunction

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock cycle: advance the model on the edge, then compare both read buses.
    task automatic cyc(input string tag);
        logic la, ra;
        @(posedge clk);
        la = l_sel && l_oe && !l_we;
        ra = r_sel && r_oe && !r_we;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_rl[i] = 1'b1; m_rr[i] = 1'b1; m_own[i] = 0;
            end
            pl = 1'b0; pr = 1'b0; hl = '0; hr = '0;
        end else begin
            if (la && !pl) hl = {DW{mflag(0, int'(l_addr))}};
            if (ra && !pr) hr = {DW{mflag(1, int'(r_addr))}};
            pl = la; pr = ra;
            for (int i = 0; i < N; i++) begin
                logic nl, nr;
                nl = (l_sel && l_we && l_addr == 3'(i)) ? l_wdata[0] : m_rl[i];
                nr = (r_sel && r_we && r_addr == 3'(i)) ? r_wdata[0] : m_rr[i];
                m_own[i] = next_own(m_own[i], nl, nr);
                m_rl[i] = nl; m_rr[i] = nr;
            end
        end
        #1;
        chk(l_rdata, (rst_n && la) ? hl : ZERO, {tag, " left R8"});
        chk(r_rdata, (rst_n && ra) ? hr : ZERO, {tag, " right R8"});
        @(negedge clk);
    endtask

    task automatic setl(input logic s, input logic o, input logic w, input logic [2:0] a, input logic [DW-1:0] d);
        l_sel = s; l_oe = o; l_we = w; l_addr = a; l_wdata = d;
    endtask

    task automatic setr(input logic s, input logic o, input logic w, input logic [2:0] a, input logic [DW-1:0] d);
        r_sel = s; r_oe = o; r_we = w; r_addr = a; r_wdata = d;
    endtask

    task automatic idle(input string tag);
        setl(0, 0, 0, 3'd0, ZERO); setr(0, 0, 0, 3'd0, ZERO); cyc(tag);
    endtask

    // Read both sides for one cycle, check literal values, then release the strobes.
    task automatic rd2(input logic [2:0] la, input logic [2:0] ra,
                       input logic [DW-1:0] el, input logic [DW-1:0] er, input string tag);
        setl(1, 1, 0, la, ZERO); setr(1, 1, 0, ra, ZERO);
        cyc(tag);
        chk(l_rdata, el, {tag, " left"});
        chk(r_rdata, er, {tag, " right"});
        idle(tag);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        setl(0, 0, 0, 3'd0, ZERO); setr(0, 0, 0, 3'd0, ZERO);
        @(negedge clk);
        // R1: reset state
        setl(1, 1, 0, 3'd0, ZERO);
        cyc("R1 reset"); cyc("R1 reset");
        rst_n = 1'b1;
        idle("R1");
        rd2(3'd0, 3'd7, ONES, ONES, "R1 free after reset");

        // R4 and R3: left requests token 3 with upper data bits set
        setl(1, 0, 1, 3'd3, 18'h3FFFE); cyc("R4 req"); idle("R4");
        rd2(3'd3, 3'd3, ZERO, ONES, "R4 left owns");
        // R2: neighbour untouched
        rd2(3'd2, 3'd4, ONES, ONES, "R2 isolation");
        // R4: non-owner release ignored
        setr(1, 0, 1, 3'd3, ONES); cyc("R4 nonowner"); idle("R4");
        rd2(3'd3, 3'd3, ZERO, ONES, "R4 nonowner release ignored");
        // R5: right pending, left releases, right takes over
        setr(1, 0, 1, 3'd3, ZERO); cyc("R5 pend"); idle("R5");
        rd2(3'd3, 3'd3, ZERO, ONES, "R5 pending blocked");
        setl(1, 0, 1, 3'd3, 18'h00001); cyc("R5 rel"); idle("R5");
        rd2(3'd3, 3'd3, ONES, ZERO, "R5 handover");
        // R6: release with nothing pending
        setr(1, 0, 1, 3'd3, 18'h00001); cyc("R6 rel"); idle("R6");
        rd2(3'd3, 3'd3, ONES, ONES, "R6 free");
        // R3: write 1 with zero upper bits does not request
        setl(1, 0, 1, 3'd1, 18'h00001); cyc("R3"); idle("R3");
        rd2(3'd1, 3'd1, ONES, ONES, "R3 bit0 only");
        // R7: same-cycle tie
        setl(1, 0, 1, 3'd5, ZERO); setr(1, 0, 1, 3'd5, ZERO); cyc("R7 tie"); idle("R7");
        rd2(3'd5, 3'd5, ZERO, ONES, "R7 left wins");
        setl(1, 0, 1, 3'd5, ONES); cyc("R7 rel"); idle("R7");
        rd2(3'd5, 3'd5, ONES, ZERO, "R7 right was pending");
        setr(1, 0, 1, 3'd5, ONES); cyc("R7"); idle("R7");
        // R10: withdrawn request
        setl(1, 0, 1, 3'd6, ZERO); cyc("R10"); setr(1, 0, 1, 3'd6, ZERO); setl(0, 0, 0, 3'd0, ZERO); cyc("R10");
        setr(1, 0, 1, 3'd6, ONES); cyc("R10"); idle("R10");
        setl(1, 0, 1, 3'd6, ONES); cyc("R10"); idle("R10");
        rd2(3'd6, 3'd6, ONES, ONES, "R10 withdrawn");
        // R9: frozen read across a handover and an index change
        setl(1, 0, 1, 3'd4, ZERO); cyc("R9"); setl(0, 0, 0, 3'd0, ZERO);
        setr(1, 0, 1, 3'd4, ZERO); cyc("R9"); idle("R9");
        setr(1, 1, 0, 3'd4, ZERO); cyc("R9 start");
        chk(r_rdata, ONES, "R9 captured");
        setl(1, 0, 1, 3'd4, ONES); cyc("R9 rel during read");
        chk(r_rdata, ONES, "R9 frozen over handover");
        setl(0, 0, 0, 3'd0, ZERO); setr(1, 1, 0, 3'd0, ZERO); cyc("R9 addr change");
        chk(r_rdata, ONES, "R9 frozen over index change");
        idle("R9");
        rd2(3'd4, 3'd4, ONES, ZERO, "R9 fresh read sees handover");
        // R8: no read means zero output
        setl(1, 0, 1, 3'd4, ONES); cyc("R8"); setl(0, 0, 0, 3'd0, ZERO); cyc("R8");
        chk(l_rdata, ZERO, "R8 idle zero");

        // Random phase, biased to low indices for collisions.
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [2:0] a;
            op = int'($urandom % 4);
            a = ($urandom % 2 == 0) ? 3'($urandom % 2) : 3'($urandom % 8);
            case (op)
                0: setl(0, 0, 0, a, ZERO);
                1: setl(1, 0, 1, a, 18'($urandom));
                default: setl(1, 1, 0, a, ZERO);
            endcase
            op = int'($urandom % 4);
            a = ($urandom % 2 == 0) ? 3'($urandom % 2) : 3'($urandom % 8);
            case (op)
                0: setr(0, 0, 0, a, ZERO);
                1: setr(1, 0, 1, a, 18'($urandom));
                default: setr(1, 1, 0, a, ZERO);
            endcase
            cyc("R9 random");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule